// File: doc/BRIEF.md
# SEW-configurable vector bit-reverse unit

This block reverses the bit order inside every element of a fixed-width slice of a vector register. The element width is picked at run time from the configured element-width setting; the operation itself carries no width. For each element the output bit at position i takes the source bit at position width-1-i, across the whole element. For elements wider than 8 bits the reversal therefore crosses byte boundaries.

Writes are gated by three rules. An element is written only if its index lies below the active vector length. Its index must also be at or above the start index. When masking is on, its mask bit must be set as well. Every element that is not written passes through the old destination value unchanged.

The block takes its inputs in a cycle where `in_valid` is high and presents the result one cycle later with `out_valid`. The slice is 128 bits by default, which gives 16, 8, 4 or 2 elements per slice.

Top module: `vbrev_unit`

## Requirements
- R1: With `sew_i`=2 (32-bit elements), result bit 32e+i equals source bit 32e+31-i for every written element e and every i in 0..31.
- R2: With `sew_i`=1 (16-bit elements), the reversal spans both bytes of each element, so the upper byte of the source lands bit-reversed in the lower byte of the result, and the reverse also holds. It is not a per-byte reverse.
- R3: With `sew_i`=0 (8-bit elements), the result equals the per-byte bit reverse of the source in every written byte.
- R4: With `sew_i`=3 (64-bit elements), each 64-bit half of the slice is fully reversed on its own, with no bits exchanged between halves.
- R5: Element k with k >= `vl_i` keeps the value of `old_i`.
- R6: Element k with k < `vstart_i` keeps the value of `old_i`.
- R7: When `mask_en_i`=1, element k is written only if `mask_i[k]`=1 and otherwise keeps `old_i`. When `mask_en_i`=0, every element in the active range is written.
- R8: If `vl_i`=0, or if `vstart_i` >= `vl_i`, the result equals `old_i` exactly.
- R9: `out_valid` is high in exactly the cycle after each cycle where `in_valid` is high, and `res_o` then holds the result for those inputs.
- R10: While `rst_n` is low at a rising clock edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are sampled in this cycle |
| src_i | input | DATA_W | Source slice to be reversed |
| old_i | input | DATA_W | Old destination slice, kept for elements that are not written |
| mask_i | input | DATA_W/8 | Mask bit k belongs to element k |
| mask_en_i | input | 1 | 1 applies the mask |
| sew_i | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| vl_i | input | VL_W | Active vector length in elements |
| vstart_i | input | VL_W | First element index that may be written |
| out_valid | output | 1 | Result is valid |
| res_o | output | DATA_W | Result slice |

## Verification
The bench applies the same source pattern at all four element widths. A design that reversed per byte, or reversed across the two 64-bit halves, would give a wrong result at widths 16, 32 and 64 even if width 8 were still correct. It places `vl_i` and `vstart_i` on element boundaries, at zero, equal to each other and beyond the element count, so an off-by-one compare shows up as one element written too many or too few. Alternating and all-zero mask patterns catch a mask that is ignored, inverted, or applied to the wrong element index, and random vectors cover the rest of the rule combinations.

// File: rtl/vbrev_pkg.sv
package vbrev_pkg;
   typedef enum logic [1:0] {
      EW8  = 2'd0,
      EW16 = 2'd1,
      EW32 = 2'd2,
      EW64 = 2'd3
   } ew_sel_e;

   localparam int unsigned EW_VARIANTS = 4;

   function automatic int unsigned ew_bits(input int unsigned sel);
      return 8 << sel;
   endfunction
endpackage

// File: rtl/vbrev_reverse.sv
module vbrev_reverse
   import vbrev_pkg::*;
#(
   parameter int unsigned DATA_W = 128
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [1:0]        sew_i,
   output logic [DATA_W-1:0] rev_o
);
   logic [EW_VARIANTS-1:0][DATA_W-1:0] cand;

   for (genvar gs = 0; gs < EW_VARIANTS; gs++) begin : g_width
      localparam int unsigned EW = ew_bits(gs);
      localparam int unsigned NE = DATA_W / EW;
      for (genvar ge = 0; ge < NE; ge++) begin : g_elem
         for (genvar gb = 0; gb < EW; gb++) begin : g_bit
            assign cand[gs][ge*EW + gb] = src_i[ge*EW + EW - 1 - gb];
         end
      end
   end

   assign rev_o = cand[sew_i];
endmodule

// File: rtl/vbrev_enable.sv
module vbrev_enable
   import vbrev_pkg::*;
#(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned VL_W   = 8
) (
   input  logic [DATA_W/8-1:0] mask_i,
   input  logic                mask_en_i,
   input  logic [1:0]          sew_i,
   input  logic [VL_W-1:0]     vl_i,
   input  logic [VL_W-1:0]     vstart_i,
   output logic [DATA_W/8-1:0] byte_we_o
);
   localparam int unsigned NBYTES = DATA_W / 8;
   localparam int unsigned MIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   always_comb begin
      for (int b = 0; b < NBYTES; b++) begin
         logic [VL_W-1:0] idx;
         logic            in_range;
         logic            mask_ok;
         idx       = VL_W'(b) >> sew_i;
         in_range  = (idx < vl_i) && (idx >= vstart_i);
         mask_ok   = !mask_en_i || mask_i[idx[MIDX_W-1:0]];
         byte_we_o[b] = in_range && mask_ok;
      end
   end
endmodule

// File: rtl/vbrev_unit.sv
module vbrev_unit
   import vbrev_pkg::*;
#(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned VL_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   src_i,
   input  logic [DATA_W-1:0]   old_i,
   input  logic [DATA_W/8-1:0] mask_i,
   input  logic                mask_en_i,
   input  logic [1:0]          sew_i,
   input  logic [VL_W-1:0]     vl_i,
   input  logic [VL_W-1:0]     vstart_i,
   output logic                out_valid,
   output logic [DATA_W-1:0]   res_o
);
   localparam int unsigned NBYTES = DATA_W / 8;

   if (DATA_W % 64 != 0 || DATA_W == 0) begin : g_bad_width
      $error("vbrev_unit: DATA_W must be a nonzero multiple of 64");
   end
   if ((1 << VL_W) <= NBYTES) begin : g_bad_vl
      $error("vbrev_unit: VL_W too narrow for the element count");
   end

   logic [DATA_W-1:0] rev;
   logic [NBYTES-1:0] byte_we;
   logic [DATA_W-1:0] merged;

   vbrev_reverse #(.DATA_W(DATA_W)) u_rev (
      .src_i (src_i),
      .sew_i (sew_i),
      .rev_o (rev)
   );

   vbrev_enable #(.DATA_W(DATA_W), .VL_W(VL_W)) u_en (
      .mask_i    (mask_i),
      .mask_en_i (mask_en_i),
      .sew_i     (sew_i),
      .vl_i      (vl_i),
      .vstart_i  (vstart_i),
      .byte_we_o (byte_we)
   );

   for (genvar gb = 0; gb < NBYTES; gb++) begin : g_merge
      assign merged[gb*8 +: 8] = byte_we[gb] ? rev[gb*8 +: 8] : old_i[gb*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) res_o <= merged;
   end
endmodule

// File: rtl/vbrev_unit_chk.sv
module vbrev_unit_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned VL_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [DATA_W-1:0]   src_i,
   input logic [DATA_W-1:0]   old_i,
   input logic [DATA_W/8-1:0] mask_i,
   input logic                mask_en_i,
   input logic [1:0]          sew_i,
   input logic [VL_W-1:0]     vl_i,
   input logic [VL_W-1:0]     vstart_i,
   input logic                out_valid,
   input logic [DATA_W-1:0]   res_o
);
   localparam int unsigned NBYTES = DATA_W / 8;

   function automatic logic [DATA_W-1:0] per_byte_flip(input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] r;
      for (int k = 0; k < DATA_W; k++) r[k] = d[(k/8)*8 + 7 - (k%8)];
      return r;
   endfunction

   p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_empty_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vstart_i >= vl_i) |=> (res_o == $past(old_i)));

   p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en_i && mask_i == '0) |=> (res_o == $past(old_i)));

   p_byte_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sew_i == 2'd0 && !mask_en_i && vstart_i == '0 && vl_i >= VL_W'(NBYTES))
      |=> (res_o == per_byte_flip($past(src_i))));

   logic rst_seen_q;
   always_ff @(posedge clk) begin
      rst_seen_q <= !rst_n;
      if (rst_seen_q) begin
         p_reset_clear_r10: assert (!out_valid);
      end
   end
endmodule

bind vbrev_unit vbrev_unit_chk #(.DATA_W(DATA_W), .VL_W(VL_W)) u_chk (.*);

// File: tb/vbrev_unit_bench.sv
`timescale 1ns/1ps
module vbrev_unit_bench;
   localparam int DATA_W = 128;
   localparam int VL_W   = 8;
   localparam int NB     = DATA_W / 8;

   typedef struct {
      logic [DATA_W-1:0] exp;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] src_i = '0;
   logic [DATA_W-1:0] old_i = '0;
   logic [NB-1:0]     mask_i = '0;
   logic              mask_en_i = 1'b0;
   logic [1:0]        sew_i = '0;
   logic [VL_W-1:0]   vl_i = '0;
   logic [VL_W-1:0]   vstart_i = '0;
   logic              out_valid;
   logic [DATA_W-1:0] res_o;

   int checks = 0;
   int fails  = 0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   vbrev_unit #(.DATA_W(DATA_W), .VL_W(VL_W)) u_vbrev_unit (.*);

   function automatic logic [DATA_W-1:0] model(
      input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] o,
      input logic [NB-1:0] m, input logic men, input logic [1:0] w,
      input int vl, input int vs);
      logic [DATA_W-1:0] r;
      int ew, ne;
      r  = o;
      ew = 8 << w;
      ne = DATA_W / ew;
      for (int e = 0; e < ne; e++) begin
         if (e < vl && e >= vs && (!men || m[e])) begin
            for (int i = 0; i < ew; i++) r[e*ew + i] = s[e*ew + ew - 1 - i];
         end
      end
      return r;
   endfunction

   task automatic send(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] o,
                       input logic [NB-1:0] m, input logic men, input logic [1:0] w,
                       input int vl, input int vs, input string tag);
      item_t it;
      src_i = s; old_i = o; mask_i = m; mask_en_i = men; sew_i = w;
      vl_i = VL_W'(vl); vstart_i = VL_W'(vs); in_valid = 1'b1;
      it.exp = model(s, o, m, men, w, vl, vs);
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R9: out_valid=1 with nothing pending (actual 1, expected 0)");
         end else begin
            item_t it;
            it = sb.pop_front();
            if (res_o !== it.exp) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", it.tag, res_o, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #200000;
      fails++;
      $display("FAIL R9: watchdog expired (actual hang, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   localparam logic [DATA_W-1:0] PAT  = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
   localparam logic [DATA_W-1:0] OLDV = 128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A;

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R10: out_valid after reset actual %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // widths, full active range
      send(PAT, OLDV, '0, 1'b0, 2'd2, 16, 0, "R1");
      send(PAT, OLDV, '0, 1'b0, 2'd1, 16, 0, "R2");
      send(128'h00FF_0000_0000_0000_0000_0000_0000_0001, OLDV, '0, 1'b0, 2'd1, 16, 0, "R2");
      send(PAT, OLDV, '0, 1'b0, 2'd0, 16, 0, "R3");
      send(PAT, OLDV, '0, 1'b0, 2'd3, 2, 0, "R4");
      send({64'h0, 64'h1}, OLDV, '0, 1'b0, 2'd3, 2, 0, "R4");
      idle(1);
      // R9: gap produces no extra out_valid
      idle(2);
      // active length
      send(PAT, OLDV, '0, 1'b0, 2'd0, 5, 0, "R5");
      send(PAT, OLDV, '0, 1'b0, 2'd2, 3, 0, "R5");
      send(PAT, OLDV, '0, 1'b0, 2'd3, 1, 0, "R5");
      send(PAT, OLDV, '0, 1'b0, 2'd0, 200, 0, "R5");
      // start index
      send(PAT, OLDV, '0, 1'b0, 2'd0, 16, 7, "R6");
      send(PAT, OLDV, '0, 1'b0, 2'd1, 8, 1, "R6");
      send(PAT, OLDV, '0, 1'b0, 2'd3, 2, 1, "R6");
      // mask
      send(PAT, OLDV, 16'hAAAA, 1'b1, 2'd0, 16, 0, "R7");
      send(PAT, OLDV, 16'h0005, 1'b1, 2'd2, 4, 0, "R7");
      send(PAT, OLDV, 16'h0000, 1'b1, 2'd1, 8, 0, "R7");
      send(PAT, OLDV, 16'h0000, 1'b0, 2'd1, 8, 0, "R7");
      send(PAT, OLDV, 16'hFFFE, 1'b1, 2'd3, 2, 0, "R7");
      // empty range
      send(PAT, OLDV, '0, 1'b0, 2'd0, 0, 0, "R8");
      send(PAT, OLDV, '0, 1'b0, 2'd2, 3, 3, "R8");
      send(PAT, OLDV, '0, 1'b0, 2'd1, 4, 9, "R8");
      idle(2);

      // random mix
      for (int n = 0; n < 60; n++) begin
         logic [DATA_W-1:0] s, o;
         s = {$urandom, $urandom, $urandom, $urandom};
         o = {$urandom, $urandom, $urandom, $urandom};
         send(s, o, NB'($urandom), 1'($urandom), 2'($urandom),
              int'($urandom_range(0, 18)), int'($urandom_range(0, 18)), "R9");
         if (n % 7 == 3) idle(1);
      end
      idle(3);

      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R9: pending results actual %0d expected 0", sb.size());
      end

      // reset in the middle of traffic
      in_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R10: out_valid during reset actual %b expected 0", out_valid);
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule